// File: doc/BRIEF.md
# Burst-Capable Bus Master Interface

This block turns transfer requests from an internal DMA engine into 32-bit memory cycles on a shared local bus. A request carries a word start address, byte enables, a direction and a beat count. The block then runs the cycles itself. It raises the address strobe in the first clock of each cycle and drives the address, byte enables and direction. It counts beats and flags the final one with a burst-last output. It completes each beat on either a normal ready or a burst ready. A burst ready lets the next beat follow on the very next clock without a new strobe.

Other masters can interrupt it. Back-off aborts the access in flight. The block floats its outputs and replays that access with a fresh strobe once back-off is released. Address-hold floats only the address lines and blocks new cycles, while data beats already under way keep completing. Losing the bus grant in the middle of a cycle has the same effect as back-off. A 16-bit bus-size mode splits every 32-bit word into two half-word accesses. The lanes used depend on the selected byte order.

The requester sees one read-data strobe per word read, one write-data advance strobe per word written, and a done pulse after the final word.

Top module: `bus_master_if`

## Requirements
- R1: After reset, and on the clock after any clock edge at which `grant` is low, `ctl_oe`, `addr_oe` and `data_oe` are all low. With `grant` high and `backoff` low at an edge, `ctl_oe` is high on the next clock. `req_ready` is high while idle.
- R2: `bus_ads` is high for exactly one clock per cycle, the first one, with `ctl_oe` and `addr_oe` high. A cycle starts only after an edge at which `grant` was high and both `addr_hold` and `backoff` were low.
- R3: Ready inputs are ignored in the strobe clock. An access therefore takes at least two clocks, and a single-word read with no wait states gives `done` exactly two clocks after its strobe clock.
- R4: A `brdy` without `rdy` on a non-final access completes it. The next access is sampled from the next clock without a new strobe, and the address rises by one word per 32-bit word. A whole burst with w wait clocks per access and M accesses uses one strobe, and `done` follows the strobe clock by 1+M(w+1) clocks.
- R5: An `rdy` on a non-final access completes it and ends the cycle. The next access starts with a fresh strobe on the following clock, so M accesses use M strobes and `done` follows the first strobe by M(w+2) clocks.
- R6: `bus_last` is high during the final access of a request and at no other completed access. The ready for that access returns the block to idle, and `done` pulses for one clock with `req_ready` high.
- R7: `backoff` beats both ready inputs at the same edge. The access is not completed and no data is returned. On the next clock all three output enables are low and `bus_ads` is low.
- R8: When back-off ends, the interrupted access is replayed with a new strobe. It carries the same address and byte enables.
- R9: On the clock after `addr_hold` is seen high, `addr_oe` is low and no strobe is issued. `ctl_oe` stays high, and data accesses already under way keep completing with unchanged timing.
- R10: With `half_mode`, each word takes two accesses, the low half (byte enables {00,be[1:0]}) first and then the high half ({be[3:2],00}). Write data puts the current half on both 16-bit lanes. Reads take the half from bits 15:0 when `big_endian` is low and from bits 31:16 when it is high, and assemble the word low half first.
- R11: `rd_valid` pulses with the assembled word on `rd_data`, and `wr_next` pulses for a write, one clock after the last access of each word completes. `wr_data` must hold the current word until `wr_next`.
- R12: A drop of `grant` during a cycle aborts and replays the access exactly as back-off does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered (taken while `req_ready`) |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 30 | Start word address (byte address bits 31:2) |
| req_be | input | 4 | Byte enables for every word |
| req_write | input | 1 | 1 = write, 0 = read |
| req_beats | input | BW | Word count, 1..MAX_BEATS (0 treated as 1) |
| half_mode | input | 1 | 16-bit bus size, latched with the request |
| big_endian | input | 1 | Selects high lanes for half-word reads, latched with the request |
| wr_data | input | 32 | Current write word |
| wr_next | output | 1 | Write word consumed, present the next |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | `rd_data` valid |
| done | output | 1 | Request finished |
| grant | input | 1 | Bus granted to this master |
| addr_hold | input | 1 | Float the address lines, start no cycle |
| backoff | input | 1 | Abort and float immediately |
| rdy | input | 1 | Normal ready, ends the cycle |
| brdy | input | 1 | Burst ready, continues the burst |
| bus_din | input | 32 | Read data from the bus |
| bus_ads | output | 1 | Address strobe (first clock of a cycle) |
| bus_addr | output | 30 | Word address |
| bus_be | output | 4 | Byte enables |
| bus_write | output | 1 | Direction |
| bus_last | output | 1 | Final access of the request |
| bus_dout | output | 32 | Write data |
| ctl_oe | output | 1 | Enable for strobe, byte enables, direction and last |
| addr_oe | output | 1 | Enable for the address lines |
| data_oe | output | 1 | Enable for the data lines |

## Verification
The hardest situation to reach is back-off landing in the same clock as a burst ready in the middle of a burst, and then a replay that must resume at the exact access that was lost. The bench's bus responder counts clocks from the first strobe of each request and raises back-off, address-hold or a grant drop at a chosen offset while it is also returning zero-wait burst readies. It remembers the address and byte enables of the aborted access and compares them with the next strobe. A near-exhaustive sweep over direction, bus size, byte order, ready type, wait count and length checks every access and every clock count arithmetically.

// File: rtl/bus_master_if.sv
`timescale 1ns/1ps
module bus_master_if #(
  parameter int MAX_BEATS = 4,
  localparam int BW = $clog2(MAX_BEATS + 1),
  localparam int IW = BW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [29:0]   req_addr,
  input  logic [3:0]    req_be,
  input  logic          req_write,
  input  logic [BW-1:0] req_beats,
  input  logic          half_mode,
  input  logic          big_endian,
  input  logic [31:0]   wr_data,
  output logic          wr_next,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic          done,
  input  logic          grant,
  input  logic          addr_hold,
  input  logic          backoff,
  input  logic          rdy,
  input  logic          brdy,
  input  logic [31:0]   bus_din,
  output logic          bus_ads,
  output logic [29:0]   bus_addr,
  output logic [3:0]    bus_be,
  output logic          bus_write,
  output logic          bus_last,
  output logic [31:0]   bus_dout,
  output logic          ctl_oe,
  output logic          addr_oe,
  output logic          data_oe
);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_T1, S_T2} st_t;

  st_t           st;
  logic [29:0]   base;
  logic [3:0]    be_r;
  logic          wr_r, half_r, big_r;
  logic [IW-1:0] nitems, item;
  logic [15:0]   lo_r;
  logic          own_q, ahold_q;

  wire in_cyc     = (st == S_T1) || (st == S_T2);
  wire can_issue  = grant && !addr_hold && !backoff;
  wire abort      = in_cyc && (backoff || !grant);
  wire last_item  = item == nitems - IW'(1);
  wire hi_sel     = half_r && item[0];
  wire word_end   = !half_r || item[0];
  wire acc_done   = (st == S_T2) && !abort && (rdy || brdy);
  wire keep_burst = brdy && !rdy && !last_item;

  wire [BW-1:0] nb       = (req_beats == '0) ? BW'(1) : req_beats;
  wire [IW-1:0] word_off = half_r ? {1'b0, item[IW-1:1]} : item;
  wire [15:0]   half_w   = hi_sel ? wr_data[31:16] : wr_data[15:0];
  wire [15:0]   lane     = big_r ? bus_din[31:16] : bus_din[15:0];

  assign req_ready = st == S_IDLE;
  assign bus_ads   = st == S_T1;
  assign bus_addr  = base + 30'(word_off);
  assign bus_be    = !half_r ? be_r : (hi_sel ? {be_r[3:2], 2'b00} : {2'b00, be_r[1:0]});
  assign bus_write = wr_r;
  assign bus_last  = in_cyc && last_item;
  assign bus_dout  = half_r ? {half_w, half_w} : wr_data;
  assign ctl_oe    = own_q;
  assign addr_oe   = own_q && !ahold_q;
  assign data_oe   = own_q && wr_r && in_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base    <= '0;
      be_r    <= '0;
      wr_r    <= 1'b0;
      half_r  <= 1'b0;
      big_r   <= 1'b0;
      nitems  <= IW'(1);
      item    <= '0;
      own_q   <= 1'b0;
      ahold_q <= 1'b0;
    end else begin
      own_q   <= grant && !backoff;
      ahold_q <= addr_hold;
      case (st)
        S_IDLE: if (req_valid) begin
          base   <= req_addr;
          be_r   <= req_be;
          wr_r   <= req_write;
          half_r <= half_mode;
          big_r  <= big_endian;
          nitems <= half_mode ? {nb, 1'b0} : {1'b0, nb};
          item   <= '0;
          st     <= S_WAIT;
        end
        S_WAIT: if (can_issue) st <= S_T1;
        S_T1:   st <= abort ? S_WAIT : S_T2;
        S_T2: begin
          if (abort) st <= S_WAIT;
          else if (acc_done) begin
            if (last_item) st <= S_IDLE;
            else begin
              item <= item + IW'(1);
              if (keep_burst)     st <= S_T2;
              else if (can_issue) st <= S_T1;
              else                st <= S_WAIT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      lo_r     <= '0;
      rd_valid <= 1'b0;
      wr_next  <= 1'b0;
      done     <= 1'b0;
    end else begin
      rd_valid <= acc_done && !wr_r && word_end;
      wr_next  <= acc_done && wr_r && word_end;
      done     <= acc_done && last_item;
      if (acc_done && !wr_r) begin
        if (!half_r)       rd_data <= bus_din;
        else if (!item[0]) lo_r    <= lane;
        else               rd_data <= {lane, lo_r};
      end
    end
  end

  // R1
  grant_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !grant |=> !ctl_oe && !addr_oe && !data_oe);

  // R2
  ads_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |-> ctl_oe && addr_oe);

  // R2
  ads_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |=> !bus_ads);

  // R3
  t1_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ads |=> !rd_valid && !wr_next && !done);

  // R7
  boff_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    backoff |=> !ctl_oe && !data_oe && !bus_ads);

  // R9
  ahold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hold |=> !addr_oe && !bus_ads);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready && !bus_ads);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !wr_next);

endmodule

// File: tb/bus_master_if_test.sv
`timescale 1ns/1ps
module bus_master_if_test;
  localparam int MB = 4;
  localparam int BW = $clog2(MB + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [29:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic req_write = 1'b0;
  logic [BW-1:0] req_beats = '0;
  logic half_mode = 1'b0, big_endian = 1'b0;
  logic [31:0] wr_data = '0, rd_data, bus_din = '0, bus_dout;
  logic wr_next, rd_valid, done;
  logic grant = 1'b0, addr_hold = 1'b0, backoff = 1'b0, rdy = 1'b0, brdy = 1'b0;
  logic bus_ads, bus_write, bus_last, ctl_oe, addr_oe, data_oe;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be;

  bus_master_if #(.MAX_BEATS(MB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_beats(req_beats),
    .half_mode(half_mode), .big_endian(big_endian), .wr_data(wr_data), .wr_next(wr_next),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done), .grant(grant),
    .addr_hold(addr_hold), .backoff(backoff), .rdy(rdy), .brdy(brdy), .bus_din(bus_din),
    .bus_ads(bus_ads), .bus_addr(bus_addr), .bus_be(bus_be), .bus_write(bus_write),
    .bus_last(bus_last), .bus_dout(bus_dout), .ctl_oe(ctl_oe), .addr_oe(addr_oe),
    .data_oe(data_oe));

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  logic [29:0] r_addr;
  logic [3:0]  r_be;
  bit r_wr, r_half, r_big;
  int r_n, r_m;
  int wait_n = 0, boff_at = -1, boff_len = 0, ahold_at = -1, ahold_len = 0, gd_at = -1, gd_len = 0;
  bit use_burst = 0, t1_junk = 0, grant_en = 0, bus_on = 0;
  int acc_cnt, ads_cnt, rd_cnt, wn_cnt, last_cnt, first_ads, done_cyc, widx;
  bit done_seen;
  bit active = 0, abort_pend = 0, prev_bo = 0, prev_ah = 0, prev_gd = 0;
  int ph = 0;
  logic [29:0] abort_addr;
  logic [3:0]  abort_be;

  function automatic logic [31:0] wval(input int k);
    return 32'hA5C30000 ^ (32'(k + 1) * 32'h01020304);
  endfunction

  function automatic logic [31:0] rval(input logic [29:0] w);
    return {2'b00, w} * 32'h9E3779B1 + 32'h0000_1357;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      if (bus_on) begin
        int rel;
        bit bo, ah, gd, rd, br;
        logic [31:0] v;
        logic [15:0] hv;
        if (rd_valid) begin
          v = rval(r_addr + 30'(rd_cnt));
          chk(rd_data == v, "R11", "read word", rd_data, v);
          rd_cnt++;
        end
        if (wr_next) begin
          wn_cnt++; widx++; wr_data = wval(widx);
        end
        if (done) begin done_seen = 1; done_cyc = cyc; end
        if (prev_bo || prev_gd)
          chk(!ctl_oe && !addr_oe && !data_oe && !bus_ads, prev_gd ? "R12" : "R7",
              "float after abort", {ctl_oe, addr_oe, data_oe, bus_ads}, 0);
        if (prev_ah) begin
          chk(!addr_oe && !bus_ads, "R9", "address floated, no strobe", {addr_oe, bus_ads}, 0);
          if (!prev_bo && !prev_gd) chk(ctl_oe, "R9", "control kept", ctl_oe, 1);
        end
        if (bus_ads) begin
          ads_cnt++;
          if (first_ads < 0) first_ads = cyc;
          active = 1; ph = 0;
          chk(ctl_oe && addr_oe, "R2", "strobe with enables", {ctl_oe, addr_oe}, 3);
          if (abort_pend) begin
            chk(bus_addr == abort_addr && bus_be == abort_be, "R8", "replayed access",
                {bus_addr, bus_be}, {abort_addr, abort_be});
            abort_pend = 0;
          end
        end
        rel = (first_ads >= 0) ? cyc - first_ads : -1;
        bo = boff_at >= 0 && rel >= boff_at && rel < boff_at + boff_len;
        ah = ahold_at >= 0 && rel >= ahold_at && rel < ahold_at + ahold_len;
        gd = gd_at >= 0 && rel >= gd_at && rel < gd_at + gd_len;
        rd = 0; br = 0;
        if (active && ph >= 1 && ph - 1 >= wait_n) begin
          if (use_burst) br = 1; else rd = 1;
        end
        if (active && ph == 0 && t1_junk) begin rd = 1; br = 1; end
        backoff = bo; addr_hold = ah; grant = grant_en && !gd; rdy = rd; brdy = br;
        v = rval(bus_addr);
        hv = (bus_be[1:0] == 2'b00) ? v[31:16] : v[15:0];
        bus_din = !r_half ? v : (r_big ? {hv, 16'hBEEF} : {16'hDEAD, hv});
        #1;
        if (active && ph >= 1 && (rd || br) && !bo && !gd) begin
          int j, k;
          logic [29:0] ea;
          logic [3:0] eb;
          logic [31:0] ed;
          logic [15:0] eh;
          j = acc_cnt;
          k = r_half ? j / 2 : j;
          ea = r_addr + 30'(k);
          eb = !r_half ? r_be : ((j % 2) ? {r_be[3:2], 2'b00} : {2'b00, r_be[1:0]});
          chk(bus_addr == ea, r_half ? "R10" : "R4", "access address", bus_addr, ea);
          chk(bus_be == eb, "R10", "access byte enables", bus_be, eb);
          chk(bus_last == (j == r_m - 1), "R6", "burst-last flag", bus_last, j == r_m - 1);
          if (bus_last) last_cnt++;
          if (r_wr) begin
            v = wval(k);
            eh = (j % 2) ? v[31:16] : v[15:0];
            ed = r_half ? {eh, eh} : v;
            chk(bus_dout == ed && data_oe, "R10", "write data on lanes", bus_dout, ed);
          end
          acc_cnt++;
          if (bus_last || rd) active = 0; else ph = 1;
        end else if (active && (bo || gd)) begin
          abort_pend = 1; abort_addr = bus_addr; abort_be = bus_be; active = 0;
        end else if (active) ph++;
        prev_bo = bo; prev_ah = ah; prev_gd = gd;
      end
    end
  end

  task automatic run(input logic [29:0] a, input logic [3:0] be, input bit wr, input int n,
                     input bit hf, input bit bg, input int w, input bit burst,
                     input int bat, input int blen, input int aat, input int alen,
                     input int gat, input int glen, input bit timing);
    int t;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    r_addr = a; r_be = be; r_wr = wr; r_n = n; r_half = hf; r_big = bg; r_m = hf ? 2 * n : n;
    wait_n = w; use_burst = burst; t1_junk = (w == 0);
    boff_at = bat; boff_len = blen; ahold_at = aat; ahold_len = alen; gd_at = gat; gd_len = glen;
    acc_cnt = 0; ads_cnt = 0; rd_cnt = 0; wn_cnt = 0; last_cnt = 0; first_ads = -1;
    done_seen = 0; done_cyc = 0; widx = 0; wr_data = wval(0); abort_pend = 0;
    req_addr = a; req_be = be; req_write = wr; req_beats = BW'(n);
    half_mode = hf; big_endian = bg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done_seen && t < 300) begin @(negedge clk); t++; end
    chk(done_seen, "R6", "done pulse seen", done_seen, 1);
    chk(req_ready, "R6", "idle after done", req_ready, 1);
    @(negedge clk); @(negedge clk);
    chk(acc_cnt == r_m, "R6", "completed accesses", acc_cnt, r_m);
    chk(last_cnt == 1, "R6", "single last access", last_cnt, 1);
    chk(rd_cnt == (wr ? 0 : n), "R11", "read strobes", rd_cnt, wr ? 0 : n);
    chk(wn_cnt == (wr ? n : 0), "R11", "write advances", wn_cnt, wr ? n : 0);
    if (timing) begin
      chk(ads_cnt == (burst ? 1 : r_m), burst ? "R4" : "R5", "strobe count",
          ads_cnt, burst ? 1 : r_m);
      chk(done_cyc - first_ads == (burst ? 1 + r_m * (w + 1) : r_m * (w + 2)), "R3",
          "clocks strobe to done", done_cyc - first_ads,
          burst ? 1 + r_m * (w + 1) : r_m * (w + 2));
    end
    boff_at = -1; ahold_at = -1; gd_at = -1;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int idx;
    logic [3:0] bes [4];
    bes[0] = 4'b1111; bes[1] = 4'b0011; bes[2] = 4'b1100; bes[3] = 4'b0110;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    bus_on = 1;
    repeat (3) @(negedge clk);
    chk(!ctl_oe && !addr_oe && !data_oe, "R1", "floated without grant",
        {ctl_oe, addr_oe, data_oe}, 0);
    chk(req_ready && !bus_ads, "R1", "idle after reset", {req_ready, bus_ads}, 2);
    grant_en = 1;
    repeat (2) @(negedge clk);
    chk(ctl_oe && addr_oe, "R1", "driven with grant", {ctl_oe, addr_oe}, 3);

    idx = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int hf = 0; hf < 2; hf++)
        for (int bu = 0; bu < 2; bu++)
          for (int w = 0; w < 3; w++)
            for (int n = 1; n <= MB; n++) begin
              run(30'h400 + 30'(idx * 16), hf ? 4'b1111 : bes[idx % 4], wr[0], n, hf[0],
                  n[0], w, bu[0], -1, 0, -1, 0, -1, 0, 1);
              idx++;
            end

    // R7 R8: back-off together with burst ready
    run(30'h2000, 4'b1111, 0, 4, 0, 0, 0, 1, 2, 3, -1, 0, -1, 0, 0);
    chk(ads_cnt == 2, "R8", "strobe reissued once", ads_cnt, 2);
    // R7 R10: back-off in half-size writes
    run(30'h2100, 4'b1111, 1, 3, 1, 0, 1, 0, 4, 2, -1, 0, -1, 0, 0);
    // R7 R10: back-off during big-endian half reads, burst
    run(30'h2200, 4'b0111, 0, 2, 1, 1, 0, 1, 1, 2, -1, 0, -1, 0, 0);
    // R9: address-hold during a burst leaves timing unchanged
    run(30'h2300, 4'b1111, 0, 4, 0, 0, 1, 1, -1, 0, 2, 3, -1, 0, 1);
    // R9: address-hold blocks fresh strobes with normal ready
    run(30'h2400, 4'b1111, 1, 3, 0, 0, 0, 0, -1, 0, 1, 3, -1, 0, 0);
    // R12: grant drop mid burst
    run(30'h2500, 4'b1111, 0, 3, 0, 0, 0, 1, -1, 0, -1, 0, 2, 2, 0);
    chk(ads_cnt == 2, "R12", "strobe reissued after grant", ads_cnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule